// File: doc/BRIEF.md
# Serial Frame Timing and Transmit Serialiser

This block turns a small set of configuration registers into everything a serial transmitter needs. It holds a mode word, a two-stage bit-rate setting (a generator count and a divider) and a control word. From these it derives a one-cycle bit enable, the decoded frame shape (data width, parity type, stop-bit count), and a character time in clock cycles. A shifter then sends one byte per request with that frame shape, and a break request holds the line low.

Software-side logic writes the registers through a single write port, selected by a two-bit code. The bit enable and the character time feed receive-side timeout logic elsewhere; the serial line output connects to the pad.

Top module: `uart_frame_gen`

## Requirements
- R1: After reset the control word reads 0x128, the mode word and divider are 0 and the generator is 15. The line idles high, the bit enable pulses once every 15 cycles and the character time is 180.
- R2: The write select codes are 0 for control, 1 for mode, 2 for generator and 3 for divider. With the mode LSB clear, the bit enable is high in exactly one cycle of every generator×(divider+1) cycles. Any write to mode, generator or divider restarts the count, so the first pulse comes in the last cycle of the first full period after the write.
- R3: When mode bit 0 is set, the period is eight times generator×(divider+1).
- R4: A generator value of zero stops the bit enable completely.
- R5: Mode bits 2:1 equal to 3 select 6 data bits, equal to 2 select 7, and any other value selects 8.
- R6: Mode bits 5:3 equal to 0 select even parity and equal to 1 select odd parity. Any other value sends no parity bit.
- R7: Mode bits 7:6 equal to 3 give one stop bit; any other value gives two.
- R8: The character time equals (1 + data bits + parity bit if present + stop bits) × bit period in cycles.
- R9: Control bits 0 (receive reset) and 1 (transmit reset) always read back as 0 after a write. All other written control bits read back unchanged.
- R10: A byte is accepted only when the shifter is idle, control bit 4 (transmit enable) is set, control bit 5 (transmit disable) is clear and no break is active.
- R11: An accepted frame starts with a low start bit in the cycle after acceptance. Data follows LSB first, then the parity bit, then high stop bits. Each bit advances on a bit-enable pulse, and the line returns high after the last stop bit.
- R12: The line is driven low whenever control bit 7 (start break) is set and bit 8 (stop break) is clear.
- R13: Writing control with bit 1 set aborts any frame in progress. The line is high and the shifter idle in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 2 | Register select: 0 control, 1 mode, 2 generator, 3 divider |
| cfg_wdata_i | input | 16 | Write data |
| tx_valid_i | input | 1 | Byte to send is present |
| tx_data_i | input | 8 | Byte to send |
| tx_ready_o | output | 1 | Shifter accepts a byte this cycle |
| txd_o | output | 1 | Serial line |
| tick_o | output | 1 | Bit-rate enable pulse |
| data_bits_o | output | 4 | Decoded data width |
| parity_en_o | output | 1 | Parity bit present |
| parity_odd_o | output | 1 | Parity is odd |
| stop_bits_o | output | 2 | Decoded stop-bit count |
| char_time_o | output | 32 | Character time in clock cycles |
| ctrl_o | output | 9 | Control word read-back |

## Verification
A wrong divider or prescaler count shows up on the bit enable within one period of the last write. The reference tracks the phase from that write and flags the first misplaced pulse. A wrong shift register, bit count or frame build shows up on the serial line at the first bit that differs, because the line is compared on every cycle against a queue of expected bits. Decode and character-time faults are visible in the same cycle as the mode write takes effect, and a missed abort or break shows on the line one cycle after the control write.

// File: rtl/uart_frame_pkg.sv
package uart_frame_pkg;
  localparam int unsigned DATA_MAX  = 8;
  localparam int unsigned FRAME_MAX = 12;
  localparam int unsigned FLEN_W    = 4;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_MODE = 2'd1,
    SEL_GEN  = 2'd2,
    SEL_DIV  = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic [3:0] data_bits;
    logic       par_en;
    logic       par_odd;
    logic [1:0] stop_bits;
  } frame_cfg_t;

  function automatic logic [FLEN_W-1:0] frame_len(frame_cfg_t c);
    return 4'd1 + c.data_bits + {3'd0, c.par_en} + {2'd0, c.stop_bits};
  endfunction

  // start bit at [0], data LSB first, parity, stops; unused upper bits stay high
  function automatic logic [FRAME_MAX-1:0] frame_bits(frame_cfg_t c, logic [DATA_MAX-1:0] d);
    logic [FRAME_MAX-1:0] b;
    logic                 par;
    logic [3:0]           pos;
    b    = '1;
    b[0] = 1'b0;
    par  = c.par_odd;
    for (int i = 0; i < DATA_MAX; i++) begin
      if (i < int'(c.data_bits)) begin
        b[i+1] = d[i];
        par    = par ^ d[i];
      end
    end
    pos = 4'd1 + c.data_bits;
    if (c.par_en) b[pos] = par;
    return b;
  endfunction
endpackage

// File: rtl/uart_mode_decode.sv
module uart_mode_decode
  import uart_frame_pkg::*;
(
  input  logic [7:0] mode_i,
  output frame_cfg_t cfg_o
);
  always_comb begin
    unique case (mode_i[2:1])
      2'b11:   cfg_o.data_bits = 4'd6;
      2'b10:   cfg_o.data_bits = 4'd7;
      default: cfg_o.data_bits = 4'd8;
    endcase
    cfg_o.par_en    = (mode_i[5:3] == 3'd0) || (mode_i[5:3] == 3'd1);
    cfg_o.par_odd   = (mode_i[5:3] == 3'd1);
    cfg_o.stop_bits = (mode_i[7:6] == 2'b11) ? 2'd1 : 2'd2;
  end

  always_comb begin
    p_width_legal_r5: assert (cfg_o.data_bits >= 4'd6 && cfg_o.data_bits <= 4'd8)
      else $error("data width out of range");
    p_stop_legal_r7: assert (cfg_o.stop_bits == 2'd1 || cfg_o.stop_bits == 2'd2)
      else $error("stop count out of range");
  end
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int unsigned GEN_W = 16,
  parameter int unsigned DIV_W = 8,
  parameter int unsigned PRE_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             src_div8_i,
  input  logic [GEN_W-1:0] gen_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [GEN_W-1:0] gen_cnt_q;
  logic [DIV_W-1:0] div_cnt_q;
  logic src_en, gen_on, gen_last, div_last;

  assign src_en   = src_div8_i ? (pre_q == '1) : 1'b1;
  assign gen_on   = (gen_i != '0);
  assign gen_last = (gen_cnt_q >= gen_i - GEN_W'(1));
  assign div_last = (div_cnt_q >= div_i);
  assign tick_o   = src_en & gen_on & gen_last & div_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q     <= '0;
      gen_cnt_q <= '0;
      div_cnt_q <= '0;
    end else if (restart_i) begin
      pre_q     <= '0;
      gen_cnt_q <= '0;
      div_cnt_q <= '0;
    end else begin
      pre_q <= pre_q + PRE_W'(1);
      if (src_en && gen_on) begin
        if (gen_last) begin
          gen_cnt_q <= '0;
          div_cnt_q <= div_last ? '0 : div_cnt_q + DIV_W'(1);
        end else begin
          gen_cnt_q <= gen_cnt_q + GEN_W'(1);
        end
      end
    end
  end

  p_gen0_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_i == '0) |-> !tick_o);
  p_restart_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (gen_cnt_q == '0 && div_cnt_q == '0));
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_frame_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                enable_i,
  input  logic                brk_i,
  input  logic                abort_i,
  input  frame_cfg_t          cfg_i,
  input  logic                valid_i,
  input  logic [DATA_MAX-1:0] data_i,
  output logic                ready_o,
  output logic                txd_o
);
  logic                 busy_q;
  logic [FRAME_MAX-1:0] sh_q;
  logic [FLEN_W-1:0]    cnt_q;

  assign ready_o = !busy_q && enable_i && !brk_i;
  assign txd_o   = brk_i ? 1'b0 : (busy_q ? sh_q[0] : 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      cnt_q  <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      cnt_q  <= '0;
    end else if (busy_q && tick_i) begin
      sh_q  <= {1'b1, sh_q[FRAME_MAX-1:1]};
      cnt_q <= cnt_q - FLEN_W'(1);
      if (cnt_q == FLEN_W'(1)) busy_q <= 1'b0;
    end else if (valid_i && ready_o) begin
      busy_q <= 1'b1;
      sh_q   <= frame_bits(cfg_i, data_i);
      cnt_q  <= frame_len(cfg_i);
    end
  end

  p_abort_idle_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> !busy_q);
  p_hold_bit_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !tick_i && !abort_i) |=> (busy_q && $stable(sh_q)));
  p_load_start_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o && !abort_i) |=> (busy_q && !sh_q[0]));
endmodule

// File: rtl/uart_frame_gen.sv
module uart_frame_gen
  import uart_frame_pkg::*;
#(
  parameter int unsigned GEN_W     = 16,
  parameter int unsigned DIV_W     = 8,
  parameter int unsigned CT_W      = 32,
  parameter int unsigned GEN_RESET = 15
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic [1:0]      cfg_sel_i,
  input  logic [15:0]     cfg_wdata_i,
  input  logic            tx_valid_i,
  input  logic [7:0]      tx_data_i,
  output logic            tx_ready_o,
  output logic            txd_o,
  output logic            tick_o,
  output logic [3:0]      data_bits_o,
  output logic            parity_en_o,
  output logic            parity_odd_o,
  output logic [1:0]      stop_bits_o,
  output logic [CT_W-1:0] char_time_o,
  output logic [8:0]      ctrl_o
);
  localparam int unsigned PER_W      = GEN_W + DIV_W + 1 + 3;
  localparam logic [8:0]  CTRL_RESET = 9'h128;
  localparam int unsigned B_TXRST = 1, B_TXEN = 4, B_TXDIS = 5, B_BRKON = 7, B_BRKOFF = 8;

  logic [8:0]       ctrl_q;
  logic [7:0]       mode_q;
  logic [GEN_W-1:0] gen_q;
  logic [DIV_W-1:0] div_q;
  frame_cfg_t       cfg;
  logic             wr_ctrl, restart, abort, brk, tx_en;
  logic [PER_W-1:0] per_base, per;

  assign wr_ctrl = cfg_we_i && (cfg_sel_i == SEL_CTRL);
  assign restart = cfg_we_i && (cfg_sel_i != SEL_CTRL);
  assign abort   = wr_ctrl && cfg_wdata_i[B_TXRST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RESET;
      mode_q <= '0;
      gen_q  <= GEN_W'(GEN_RESET);
      div_q  <= '0;
    end else if (cfg_we_i) begin
      unique case (cfg_sel_i)
        SEL_CTRL: ctrl_q <= cfg_wdata_i[8:0] & 9'h1FC; // reset bits self-clear
        SEL_MODE: mode_q <= cfg_wdata_i[7:0];
        SEL_GEN:  gen_q  <= cfg_wdata_i[GEN_W-1:0];
        default:  div_q  <= cfg_wdata_i[DIV_W-1:0];
      endcase
    end
  end

  assign brk   = ctrl_q[B_BRKON] && !ctrl_q[B_BRKOFF];
  assign tx_en = ctrl_q[B_TXEN] && !ctrl_q[B_TXDIS];

  uart_mode_decode u_dec (
    .mode_i (mode_q),
    .cfg_o  (cfg)
  );

  uart_baud_gen #(.GEN_W(GEN_W), .DIV_W(DIV_W)) u_baud (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (restart),
    .src_div8_i (mode_q[0]),
    .gen_i      (gen_q),
    .div_i      (div_q),
    .tick_o     (tick_o)
  );

  uart_tx_shift u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_o),
    .enable_i (tx_en),
    .brk_i    (brk),
    .abort_i  (abort),
    .cfg_i    (cfg),
    .valid_i  (tx_valid_i),
    .data_i   (tx_data_i),
    .ready_o  (tx_ready_o),
    .txd_o    (txd_o)
  );

  assign per_base = PER_W'(gen_q) * (PER_W'(div_q) + PER_W'(1));
  assign per      = mode_q[0] ? (per_base << 3) : per_base;

  assign char_time_o  = CT_W'(per) * CT_W'(frame_len(cfg));
  assign data_bits_o  = cfg.data_bits;
  assign parity_en_o  = cfg.par_en;
  assign parity_odd_o = cfg.par_odd;
  assign stop_bits_o  = cfg.stop_bits;
  assign ctrl_o       = ctrl_q;

  p_ctrl_selfclear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl |=> (ctrl_o[1:0] == 2'b00 && ctrl_o[8:2] == $past(cfg_wdata_i[8:2])));
  p_break_line_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && cfg_wdata_i[B_BRKON] && !cfg_wdata_i[B_BRKOFF]) |=> !txd_o);
endmodule

// File: tb/uart_frame_gen_test.sv
module uart_frame_gen_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic        tx_valid = 1'b0;
  logic [7:0]  tx_data = '0;
  logic        tx_ready_o, txd_o, tick_o, parity_en_o, parity_odd_o;
  logic [3:0]  data_bits_o;
  logic [1:0]  stop_bits_o;
  logic [31:0] char_time_o;
  logic [8:0]  ctrl_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_frame_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .tx_valid_i(tx_valid), .tx_data_i(tx_data),
    .tx_ready_o(tx_ready_o), .txd_o(txd_o), .tick_o(tick_o),
    .data_bits_o(data_bits_o), .parity_en_o(parity_en_o),
    .parity_odd_o(parity_odd_o), .stop_bits_o(stop_bits_o),
    .char_time_o(char_time_o), .ctrl_o(ctrl_o)
  );

  // reference model
  int m_ctrl = 'h128, m_mode = 0, m_gen = 15, m_div = 0, phase = 0;
  bit q[$];
  int checks = 0, errors = 0, ticks = 0;

  function automatic int m_per();
    return m_gen * (m_div + 1) * (((m_mode & 1) != 0) ? 8 : 1);
  endfunction
  function automatic int m_w();
    int f = (m_mode >> 1) & 3;
    return (f == 3) ? 6 : ((f == 2) ? 7 : 8);
  endfunction
  function automatic int m_pe();
    return (((m_mode >> 3) & 7) < 2) ? 1 : 0;
  endfunction
  function automatic int m_po();
    return (((m_mode >> 3) & 7) == 1) ? 1 : 0;
  endfunction
  function automatic int m_sb();
    return (((m_mode >> 6) & 3) == 3) ? 1 : 2;
  endfunction
  function automatic bit m_brk();
    return ((m_ctrl >> 7) & 1) == 1 && ((m_ctrl >> 8) & 1) == 0;
  endfunction
  function automatic bit m_tick();
    int p = m_per();
    return (m_gen != 0) && ((phase % p) == p - 1);
  endfunction
  function automatic bit m_ready();
    return q.size() == 0 && ((m_ctrl >> 4) & 1) == 1 && ((m_ctrl >> 5) & 1) == 0 && !m_brk();
  endfunction
  function automatic bit m_txd();
    if (m_brk()) return 1'b0;
    return (q.size() != 0) ? q[0] : 1'b1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 'h128; m_mode = 0; m_gen = 15; m_div = 0; phase = 0;
      q.delete();
    end else begin
      bit tk, rd, par;
      tk = m_tick();
      rd = m_ready();
      if (cfg_we && cfg_sel == 2'd0 && cfg_wdata[1]) q.delete();
      else if (q.size() != 0 && tk) void'(q.pop_front());
      else if (tx_valid && rd) begin
        q.push_back(1'b0);
        par = (m_po() != 0);
        for (int i = 0; i < m_w(); i++) begin
          q.push_back(tx_data[i]);
          par = par ^ tx_data[i];
        end
        if (m_pe() != 0) q.push_back(par);
        for (int i = 0; i < m_sb(); i++) q.push_back(1'b1);
      end
      if (cfg_we && cfg_sel != 2'd0) phase = 0; else phase = phase + 1;
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: m_ctrl = int'(cfg_wdata[8:0]) & 'h1FC;
          2'd1: m_mode = int'(cfg_wdata[7:0]);
          2'd2: m_gen  = int'(cfg_wdata);
          default: m_div = int'(cfg_wdata[7:0]);
        endcase
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    int len;
    len = 1 + m_w() + m_pe() + m_sb();
    chk("R2 tick", int'(tick_o), int'(m_tick()));
    if (tick_o) ticks++;
    chk("R11 txd", int'(txd_o), int'(m_txd()));
    chk("R10 ready", int'(tx_ready_o), int'(m_ready()));
    chk("R8 char_time", int'(char_time_o), len * m_per());
    chk("R5 data_bits", int'(data_bits_o), m_w());
    chk("R6 parity_en", int'(parity_en_o), m_pe());
    chk("R6 parity_odd", int'(parity_odd_o), m_po());
    chk("R7 stop_bits", int'(stop_bits_o), m_sb());
    chk("R9 ctrl", int'(ctrl_o), m_ctrl);
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(logic [1:0] sel, logic [15:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    cyc();
    cfg_we = 1'b0;
  endtask

  task automatic send(logic [7:0] d);
    for (int i = 0; i < 5000 && !tx_ready_o; i++) cyc();
    tx_valid = 1'b1; tx_data = d;
    cyc();
    tx_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 5000 && !tx_ready_o; i++) cyc();
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 ctrl reset", int'(ctrl_o), 'h128);
    chk("R1 idle line", int'(txd_o), 1);
    chk("R1 char_time reset", int'(char_time_o), 180);
    ticks = 0;
    run(45);
    chk("R1 tick every 15", ticks, 3);

    // R9 self-clear, enable tx
    wr(2'd0, 16'h117);
    chk("R9 reset bits clear", int'(ctrl_o), 'h114);

    // R2 period gen*(div+1)
    wr(2'd3, 16'd1);
    wr(2'd2, 16'd4);
    ticks = 0;
    run(40);
    chk("R2 period 8", ticks, 5);

    // R11 frames in several shapes
    send(8'hA5);
    drain();
    wr(2'd1, 16'h00CE);
    chk("R5 six bits", int'(data_bits_o), 6);
    chk("R6 odd parity", int'(parity_odd_o), 1);
    chk("R7 one stop", int'(stop_bits_o), 1);
    send(8'h3F);
    drain();
    wr(2'd1, 16'h0014);
    chk("R5 seven bits", int'(data_bits_o), 7);
    chk("R6 no parity", int'(parity_en_o), 0);
    chk("R7 two stops", int'(stop_bits_o), 2);
    send(8'h5A);
    send(8'h81);
    drain();
    wr(2'd1, 16'h0002);
    chk("R8 char_time 8 bit even", int'(char_time_o), 12 * 8);
    send(8'hC3);
    drain();

    // R3 divide-by-8 source
    wr(2'd3, 16'd0);
    wr(2'd2, 16'd2);
    wr(2'd1, 16'h0001);
    ticks = 0;
    run(64);
    chk("R3 period 16", ticks, 4);
    send(8'h96);
    drain();

    // R4 zero generator
    wr(2'd2, 16'd0);
    ticks = 0;
    run(100);
    chk("R4 no tick", ticks, 0);
    chk("R4 char_time zero", int'(char_time_o), 0);

    // R12 break
    wr(2'd2, 16'd3);
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'h094);
    chk("R12 break low", int'(txd_o), 0);
    chk("R12 no accept in break", int'(tx_ready_o), 0);
    run(10);
    wr(2'd0, 16'h194);
    chk("R12 break released", int'(txd_o), 1);

    // R13 abort mid frame
    send(8'h00);
    run(12);
    wr(2'd0, 16'h116);
    chk("R13 line high after abort", int'(txd_o), 1);
    chk("R13 idle after abort", int'(tx_ready_o), 1);

    // R10 disable wins over enable
    wr(2'd0, 16'h134);
    chk("R10 disabled", int'(tx_ready_o), 0);
    tx_valid = 1'b1; tx_data = 8'h00;
    run(20);
    tx_valid = 1'b0;
    chk("R10 line stays idle", int'(txd_o), 1);
    wr(2'd0, 16'h114);
    send(8'hFF);
    drain();
    run(5);

    finish_run();
  end
endmodule